// File: doc/BRIEF.md
# Backup Sleep Sequencer

This block sits in the always-on part of a chip and steps the core power domain into and out of its deepest sleep state. While the chip sleeps, the core supply is off and everything held in the core is treated as lost. The backup domain, which holds this block, keeps its power. The I/O pads are frozen in their last configuration for the whole time the core is not running.

Sleep is entered when the processor issues a wait-for-interrupt request while its deep-sleep flag and the backup-select flag are both set. The block leaves sleep in one of two ways:

- **Reset exit.** A reset source fires. A full reset sequence runs, and the reset source is recorded.
- **Wake exit.** An enabled wake source fires. Only the core domain is reset. The run mode that was active before sleep is restored, a backup flag is recorded in place of a reset source, and the triggering wake source is logged separately.

On both exits the core reset stays asserted until the core supply reports ready.

The sequencer has four states:

- `ST_RUN`: the core is powered and out of reset.
- `ST_SLEEP`: the core is off and the pads are retained.
- `ST_RSTW`: the core is powered and held in reset after a reset source.
- `ST_WAKEW`: the core is powered and held in reset after a wake.

Its transitions are:

- **T_POR**: a backup-domain reset forces `ST_RSTW`.
- **T_ENTER**: `ST_RUN` to `ST_SLEEP` when the entry condition holds.
- **T_RESET**: any state to `ST_RSTW` when any reset source is high.
- **T_WAKE**: `ST_SLEEP` to `ST_WAKEW` when an enabled wake source fires and no reset source is high.
- **T_RELEASE**: `ST_RSTW` or `ST_WAKEW` to `ST_RUN` when the core supply is ready. From `ST_RSTW` this also requires that no reset source is high.

The 32 kHz clock source select and its enable are captured only while running, and they are held through sleep.

Top module: `bkup_seq`

## Requirements
- R1: T_ENTER happens only when wfi_req, deep_sleep and bkup_sel are all 1 in the same cycle and no reset source is high. One cycle later core_pwr_en=0 and core_rst_n=0. If any of the three is 0, the core stays running.
- R2: While core_pwr_en=0, core_rst_n=0 and io_retain=1. io_retain is 0 only in ST_RUN, that is, whenever core_rst_n=1.
- R3: The reset sources map to rst_src as follows:
  - bit 0: supply brown-out
  - bit 1: core brown-out
  - bit 2: watchdog
  - bit 3: external pin

  Any high reset source, in any state, leads one cycle later to ST_RSTW. In ST_RSTW, core_pwr_en=1 and core_rst_n=0. On entry to ST_RSTW, rst_cause[3:0] takes the rst_src value and rst_cause[4] (the backup flag) is 0, wake_cause clears and run_mode_o returns to 0. Sources that fire while already in ST_RSTW are ORed into rst_cause.
- R4: From ST_RSTW, core_rst_n rises one cycle after a cycle in which core_ready=1 and rst_src=0. It never rises while core_ready=0.
- R5: The level wake sources map to wake_src as follows, and each is gated by wake_en at the same bit:
  - bit 0: supply brown-out interrupt
  - bit 1: core brown-out interrupt
  - bit 2: timer alarm
  - bit 3: timer periodic
  - bit 4: timer overflow
  - bit 5: watchdog interrupt

  A source whose enable bit is 0 has no effect: the core stays off.
- R6: An external line ext_line[i] with ext_en[i]=1 wakes the chip only on a change of level, rising or falling. A line held steady at either level does not wake it.
- R7: T_WAKE leads one cycle later to ST_WAKEW with core_pwr_en=1 and core_rst_n=0. At that point rst_cause=5'b10000. wake_cause holds the enabled level hits in bits [5:0] and the external-line edges in bits [9:6]. After T_RELEASE, run_mode_o equals the run_mode_i value sampled in the last cycle before T_ENTER.
- R8: If a reset source and a wake source are high in the same sleep cycle, the reset path wins: rst_cause[4]=0 and wake_cause=0.
- R9: clk32_sel_o and clk32_on_o follow clk32_sel_i and clk32_en_i one cycle late, and only while in ST_RUN. Outside ST_RUN they hold their values.
- R10: After rst_n the block is in ST_RSTW with the following values, and it stays in reset until core_ready=1:
  - core_pwr_en=1, core_rst_n=0, io_retain=1
  - rst_cause=0, wake_cause=0
  - run_mode_o=0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Backup-domain reset, active low |
| wfi_req | input | 1 | Wait-for-interrupt request |
| deep_sleep | input | 1 | Deep-sleep flag |
| bkup_sel | input | 1 | Backup-mode select flag |
| run_mode_i | input | 2 | Current run mode |
| rst_src | input | 4 | Reset sources |
| wake_src | input | 6 | Level wake sources |
| wake_en | input | 6 | Wake source enables |
| ext_line | input | 4 | External interrupt lines |
| ext_en | input | 4 | External line wake enables |
| core_ready | input | 1 | Core supply stable |
| clk32_sel_i | input | 1 | 32 kHz source select request |
| clk32_en_i | input | 1 | 32 kHz clock enable request |
| core_pwr_en | output | 1 | Core power domain enable |
| core_rst_n | output | 1 | Core domain reset, active low |
| io_retain | output | 1 | Pad configuration retention |
| run_mode_o | output | 2 | Run mode to restore |
| clk32_sel_o | output | 1 | Held 32 kHz source select |
| clk32_on_o | output | 1 | Held 32 kHz clock enable |
| rst_cause | output | 5 | Reset cause bits [3:0] and backup flag at bit [4] |
| wake_cause | output | 10 | Wake cause: level sources [5:0] and external lines [9:6] |

## Verification
A wrong state shows up within one clock at core_pwr_en, core_rst_n and io_retain, because those outputs decode the state directly. A sleep state reached by mistake drops the core supply. A missed wait state releases core reset before core_ready. A mix-up between the two exit paths appears in the cycle after the exit as a wrong backup flag or a non-empty wake_cause. A lost saved mode is seen as a wrong run_mode_o in the first cycle after release.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
    localparam int NUM_RST  = 4;
    localparam int NUM_WAKE = 6;
    localparam int NUM_EXT  = 4;
    localparam int MODE_W   = 2;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_RSTW  = 2'd2,
        ST_WAKEW = 2'd3
    } bkup_state_e;
endpackage

// File: rtl/bkup_edge.sv
module bkup_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line,
    input  logic [N-1:0] en,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= line;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign hit[i] = en[i] & (line[i] ^ prev_q[i]);
    end
endmodule

// File: rtl/bkup_fsm.sv
module bkup_fsm
    import bkup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enter,
    input  logic        rst_any,
    input  logic        wake_any,
    input  logic        core_ready,
    output bkup_state_e st,
    output logic        ev_rst,
    output logic        ev_wake,
    output logic        core_pwr_en,
    output logic        core_rst_n,
    output logic        io_retain
);
    bkup_state_e st_nx;

    // state register (T_POR lands in ST_RSTW)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RSTW;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx   = st;
        ev_rst  = rst_any;
        ev_wake = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (rst_any)    st_nx = ST_RSTW;   // T_RESET
                else if (enter) st_nx = ST_SLEEP;  // T_ENTER
            end
            ST_SLEEP: begin
                if (rst_any) st_nx = ST_RSTW;      // T_RESET, wins over wake
                else if (wake_any) begin
                    st_nx   = ST_WAKEW;            // T_WAKE
                    ev_wake = 1'b1;
                end
            end
            ST_RSTW: begin
                if (!rst_any && core_ready) st_nx = ST_RUN;  // T_RELEASE
            end
            ST_WAKEW: begin
                if (rst_any)         st_nx = ST_RSTW;  // T_RESET
                else if (core_ready) st_nx = ST_RUN;   // T_RELEASE
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_RUN:   begin core_pwr_en = 1'b1; core_rst_n = 1'b1; io_retain = 1'b0; end
            ST_SLEEP: begin core_pwr_en = 1'b0; core_rst_n = 1'b0; io_retain = 1'b1; end
            ST_RSTW:  begin core_pwr_en = 1'b1; core_rst_n = 1'b0; io_retain = 1'b1; end
            ST_WAKEW: begin core_pwr_en = 1'b1; core_rst_n = 1'b0; io_retain = 1'b1; end
        endcase
    end
endmodule

// File: rtl/bkup_status.sv
module bkup_status #(
    parameter int NR  = 4,
    parameter int NH  = 10,
    parameter int MW  = 2,
    parameter logic [MW-1:0] MODE_DEF = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_rst,
    input  logic          ev_wake,
    input  logic          in_run,
    input  logic          in_rstw,
    input  logic [NR-1:0] rst_src,
    input  logic [NH-1:0] hits,
    input  logic [MW-1:0] run_mode_i,
    input  logic          clk32_sel_i,
    input  logic          clk32_en_i,
    output logic [NR:0]   rst_cause,
    output logic [NH-1:0] wake_cause,
    output logic [MW-1:0] run_mode_o,
    output logic          clk32_sel_o,
    output logic          clk32_on_o
);
    localparam logic [NR:0] BKUP_FLAG = {1'b1, {NR{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_cause   <= '0;
            wake_cause  <= '0;
            run_mode_o  <= MODE_DEF;
            clk32_sel_o <= 1'b0;
            clk32_on_o  <= 1'b0;
        end else if (ev_rst) begin
            rst_cause  <= in_rstw ? (rst_cause | {1'b0, rst_src}) : {1'b0, rst_src};
            wake_cause <= '0;
            run_mode_o <= MODE_DEF;
        end else if (ev_wake) begin
            rst_cause  <= BKUP_FLAG;
            wake_cause <= hits;
        end else if (in_run) begin
            run_mode_o  <= run_mode_i;
            clk32_sel_o <= clk32_sel_i;
            clk32_on_o  <= clk32_en_i;
        end
    end
endmodule

// File: rtl/bkup_seq.sv
module bkup_seq
    import bkup_pkg::*;
#(
    parameter int NR = NUM_RST,
    parameter int NW = NUM_WAKE,
    parameter int NE = NUM_EXT,
    parameter int MW = MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req,
    input  logic             deep_sleep,
    input  logic             bkup_sel,
    input  logic [MW-1:0]    run_mode_i,
    input  logic [NR-1:0]    rst_src,
    input  logic [NW-1:0]    wake_src,
    input  logic [NW-1:0]    wake_en,
    input  logic [NE-1:0]    ext_line,
    input  logic [NE-1:0]    ext_en,
    input  logic             core_ready,
    input  logic             clk32_sel_i,
    input  logic             clk32_en_i,
    output logic             core_pwr_en,
    output logic             core_rst_n,
    output logic             io_retain,
    output logic [MW-1:0]    run_mode_o,
    output logic             clk32_sel_o,
    output logic             clk32_on_o,
    output logic [NR:0]      rst_cause,
    output logic [NW+NE-1:0] wake_cause
);
    localparam int NH = NW + NE;

    logic [NE-1:0] ext_hit;
    logic [NH-1:0] hits;
    bkup_state_e   st;
    logic          ev_rst, ev_wake;

    bkup_edge #(.N(NE)) u_edge (
        .clk(clk), .rst_n(rst_n), .line(ext_line), .en(ext_en), .hit(ext_hit)
    );

    assign hits = {ext_hit, wake_src & wake_en};

    bkup_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .enter(wfi_req & deep_sleep & bkup_sel),
        .rst_any(|rst_src), .wake_any(|hits), .core_ready(core_ready),
        .st(st), .ev_rst(ev_rst), .ev_wake(ev_wake),
        .core_pwr_en(core_pwr_en), .core_rst_n(core_rst_n), .io_retain(io_retain)
    );

    bkup_status #(.NR(NR), .NH(NH), .MW(MW)) u_status (
        .clk(clk), .rst_n(rst_n), .ev_rst(ev_rst), .ev_wake(ev_wake),
        .in_run(st == ST_RUN), .in_rstw(st == ST_RSTW),
        .rst_src(rst_src), .hits(hits), .run_mode_i(run_mode_i),
        .clk32_sel_i(clk32_sel_i), .clk32_en_i(clk32_en_i),
        .rst_cause(rst_cause), .wake_cause(wake_cause), .run_mode_o(run_mode_o),
        .clk32_sel_o(clk32_sel_o), .clk32_on_o(clk32_on_o)
    );
endmodule

// File: rtl/bkup_seq_chk.sv
module bkup_seq_chk #(
    parameter int NR = 4,
    parameter int NH = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wfi_req,
    input logic          deep_sleep,
    input logic          bkup_sel,
    input logic [NR-1:0] rst_src,
    input logic          core_ready,
    input logic          core_pwr_en,
    input logic          core_rst_n,
    input logic          io_retain,
    input logic          clk32_sel_o,
    input logic [NR:0]   rst_cause,
    input logic [NH-1:0] wake_cause
);
    p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n && wfi_req && deep_sleep && bkup_sel && (rst_src == '0)
        |=> !core_pwr_en && !core_rst_n);

    p_noentry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n && !(wfi_req && deep_sleep && bkup_sel) && (rst_src == '0)
        |=> core_rst_n);

    p_off_retained_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_en |-> io_retain && !core_rst_n);

    p_retain_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        io_retain != core_rst_n);

    p_reset_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_src != '0) |=> core_pwr_en && !core_rst_n && !rst_cause[NR]);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> $past(core_ready));

    p_bkflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_cause[NR]) |-> $past(!core_pwr_en));

    p_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_en && (rst_src != '0) |=> !rst_cause[NR] && (wake_cause == '0));

    p_clk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n && $past(!core_rst_n) |-> $stable(clk32_sel_o));
endmodule

bind bkup_seq bkup_seq_chk #(.NR(NR), .NH(NW + NE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .deep_sleep(deep_sleep),
    .bkup_sel(bkup_sel), .rst_src(rst_src), .core_ready(core_ready),
    .core_pwr_en(core_pwr_en), .core_rst_n(core_rst_n), .io_retain(io_retain),
    .clk32_sel_o(clk32_sel_o), .rst_cause(rst_cause), .wake_cause(wake_cause)
);

// File: tb/bkup_seq_test.sv
module bkup_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wfi_req = 0, deep_sleep = 0, bkup_sel = 0;
    logic [1:0] run_mode_i = 0;
    logic [3:0] rst_src = 0;
    logic [5:0] wake_src = 0, wake_en = 6'h3f;
    logic [3:0] ext_line = 0, ext_en = 4'hf;
    logic       core_ready = 0, clk32_sel_i = 0, clk32_en_i = 0;
    logic       core_pwr_en, core_rst_n, io_retain, clk32_sel_o, clk32_on_o;
    logic [1:0] run_mode_o;
    logic [4:0] rst_cause;
    logic [9:0] wake_cause;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkup_seq uut (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .deep_sleep(deep_sleep),
        .bkup_sel(bkup_sel), .run_mode_i(run_mode_i), .rst_src(rst_src),
        .wake_src(wake_src), .wake_en(wake_en), .ext_line(ext_line), .ext_en(ext_en),
        .core_ready(core_ready), .clk32_sel_i(clk32_sel_i), .clk32_en_i(clk32_en_i),
        .core_pwr_en(core_pwr_en), .core_rst_n(core_rst_n), .io_retain(io_retain),
        .run_mode_o(run_mode_o), .clk32_sel_o(clk32_sel_o), .clk32_on_o(clk32_on_o),
        .rst_cause(rst_cause), .wake_cause(wake_cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // core outputs packed as {core_pwr_en, core_rst_n, io_retain}
    function automatic logic [2:0] core_st();
        return {core_pwr_en, core_rst_n, io_retain};
    endfunction

    task automatic release_core();
        core_ready = 1; step(1); core_ready = 0;
    endtask

    task automatic enter_sleep();
        deep_sleep = 1; bkup_sel = 1; wfi_req = 1; step(1); wfi_req = 0;
    endtask

    task automatic t_por();
        step(2);
        rst_n = 1; step(1);
        check("R10 por core", core_st(), 3'b101);
        check("R10 por causes", {rst_cause, wake_cause}, 0);
        check("R10 por mode", run_mode_o, 0);
        step(3);
        check("R10 held without ready", core_rst_n, 0);
        release_core();
        check("R4 released", core_st(), 3'b110);
    endtask

    task automatic t_entry_gate();
        deep_sleep = 0; bkup_sel = 1; wfi_req = 1; step(1); wfi_req = 0; step(1);
        check("R1 no deep_sleep", core_st(), 3'b110);
        deep_sleep = 1; bkup_sel = 0; wfi_req = 1; step(1); wfi_req = 0; step(1);
        check("R1 no bkup_sel", core_st(), 3'b110);
        bkup_sel = 1; step(2);
        check("R1 no wfi", core_st(), 3'b110);
        deep_sleep = 0; bkup_sel = 0;
    endtask

    task automatic t_level_wake();
        run_mode_i = 2; clk32_sel_i = 1; clk32_en_i = 1; step(2);
        check("R9 follows in run", {clk32_sel_o, clk32_on_o}, 2'b11);
        enter_sleep();
        check("R1 entered", core_st(), 3'b001);
        check("R2 retained", io_retain, 1);
        run_mode_i = 1; clk32_sel_i = 0; clk32_en_i = 0;
        wake_en = 6'b111110; wake_src = 6'b000001; step(3);
        check("R5 disabled ignored", core_st(), 3'b001);
        check("R9 held in sleep", {clk32_sel_o, clk32_on_o}, 2'b11);
        wake_src = 6'b000101; step(1); wake_src = 0;
        check("R7 wait state", core_st(), 3'b101);
        check("R7 backup flag", rst_cause, 5'b10000);
        check("R5 R7 wake cause masked", wake_cause, 10'h004);
        step(2);
        check("R4 held while not ready", core_rst_n, 0);
        release_core();
        check("R7 released", core_st(), 3'b110);
        check("R7 mode restored", run_mode_o, 2);
        step(1);
        check("R9 follows again", {clk32_sel_o, clk32_on_o}, 2'b00);
        wake_en = 6'h3f; deep_sleep = 0; bkup_sel = 0; run_mode_i = 3;
    endtask

    task automatic t_ext_edge();
        ext_line = 4'b0100; step(2);
        enter_sleep();
        step(3);
        check("R6 steady high ignored", core_st(), 3'b001);
        ext_line = 4'b0000; step(1);
        check("R6 falling edge wakes", core_st(), 3'b101);
        check("R6 cause bit 8", wake_cause, 10'h100);
        release_core();
        check("R7 mode restored 3", run_mode_o, 3);
        ext_en = 4'b1110; enter_sleep();
        ext_line = 4'b0001; step(2);
        check("R6 disabled line ignored", core_st(), 3'b001);
        ext_line = 4'b1001; step(1);
        check("R6 rising edge wakes", wake_cause, 10'h200);
        release_core();
        ext_line = 0; ext_en = 4'hf; step(1);
    endtask

    task automatic t_reset_exit();
        enter_sleep();
        rst_src = 4'b0100; core_ready = 1; step(1);
        check("R3 reset wait", core_st(), 3'b101);
        check("R3 cause watchdog", rst_cause, 5'b00100);
        check("R3 wake cause cleared", wake_cause, 0);
        check("R3 mode default", run_mode_o, 0);
        rst_src = 4'b1000; step(2);
        check("R4 held while source high", core_rst_n, 0);
        check("R3 accumulate", rst_cause, 5'b01100);
        rst_src = 0; step(1); core_ready = 0;
        check("R4 release after source drop", core_st(), 3'b110);
    endtask

    task automatic t_priority();
        run_mode_i = 1; step(1);
        enter_sleep();
        rst_src = 4'b0010; wake_src = 6'b001000; step(1);
        rst_src = 0; wake_src = 0;
        check("R8 reset wins", rst_cause, 5'b00010);
        check("R8 no wake cause", wake_cause, 0);
        release_core();
        check("R8 mode default", run_mode_o, 0);
        rst_src = 4'b0001; step(1); rst_src = 0;
        check("R3 reset from run", {core_st(), rst_cause}, {3'b101, 5'b00001});
        release_core();
    endtask

    initial begin : wdog
        #(CLK_PERIOD * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_por();
        t_entry_gate();
        t_level_wake();
        t_ext_edge();
        t_reset_exit();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule